// File: doc/BRIEF.md
# Character Scanline Expansion Sequencer

This block walks the scan lines of one text row of an on-screen character display. For every horizontal line it says which of the 18 glyph lines the font fetch should read, or whether the line is blank spacing between rows. A row begins with a `row_start` pulse. Each later `line_strobe`, one per horizontal line, moves the sequencer one scan line forward. The final scan line of the row is marked so that the row counter upstream can step to the next row.

Glyph height is set by a 7-bit height word. The low five bits insert single repeats of glyph lines. They are binary weighted with weights 1, 2, 4, 8 and 16, and the total is capped at 17. The inserted repeats are spread evenly over the glyph by a modulo-18 accumulator. The top two bits can repeat the whole glyph one or two extra times. A per-row double-height flag then emits every glyph scan line twice. After the glyph lines come 0 to 31 blank lines of row spacing. All settings are captured at `row_start` and held for the whole row.

Top module: `glyph_row_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first `row_start`, `line_active`, `blank_line`, `row_end` and `glyph_line` are all 0.
- R2: In the cycle after `row_start` is high, `line_active` is 1, `blank_line` is 0 and `glyph_line` is 0. Outputs change only in the cycle after `row_start` or `line_strobe` was high. Each strobe moves the row forward exactly one scan line.
- R3: With height word 0, spacing 0 and double height off, a row is exactly the 18 glyph lines 0 to 17, in ascending order, each shown once.
- R4: The inserted count n is the weighted sum of height bits 4:0, with bit i weighing 2^i, limited to 17. Each glyph line is emitted at most once more because of n. Glyph lines never go backwards within a row.
- R5: Glyph line g (0 to 17) receives an inserted repeat exactly when floor((g+1)*n/18) is greater than floor(g*n/18).
- R6: Height bits 6:5 select whole-glyph repeats: 00 or 01 gives none, 10 gives one and 11 gives two. For example, height word 0x4A gives 46 glyph scan lines.
- R7: When the double-height flag is 1 at `row_start`, every glyph scan line that R3 to R6 produce is held for two consecutive strobes. Spacing lines are not doubled.
- R8: After the glyph lines, S blank lines follow, where S is the 5-bit spacing value. On these lines `blank_line` is 1 and `glyph_line` is 0. S = 0 gives none.
- R9: `row_end` is 1 for exactly the final scan line of the row. That is the last spacing line, or the last glyph line when S = 0. The strobe that ends it drops `line_active` to 0.
- R10: Height word, double-height flag and spacing are sampled at `row_start`. Changing them during a row has no effect on that row.
- R11: A `row_start` during an active row restarts the sequence from glyph line 0 with the newly sampled settings. A `line_strobe` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| height_ctl | input | 7 | Height word: bits 4:0 insert lines, bits 6:5 select whole-glyph repeat |
| dbl_height | input | 1 | Double-height flag for the row being started |
| row_space | input | 5 | Blank lines appended after the glyph lines |
| line_strobe | input | 1 | One-cycle pulse per horizontal line; moves to the next scan line |
| row_start | input | 1 | One-cycle pulse that begins a row and samples the settings |
| line_active | output | 1 | A row scan line is being presented |
| glyph_line | output | 5 | Glyph line index to fetch (0 to 17); 0 when not on a glyph line |
| blank_line | output | 1 | Current scan line is blank spacing |
| row_end | output | 1 | Current scan line is the last one of the row |

## Verification
A wrong repeat count or a misplaced accumulator wrap shows at the ports on the very strobe where it happens. `glyph_line` then holds one line too long or too short, and the rest of the row is shifted. For that reason the bench compares every cycle of every row with a scan-line list it builds from the requirements. A stale sampled setting or a wrong spacing counter shows as `row_end` in the wrong cycle, or as `line_active` falling early or late. Such errors appear within at most one row, which is at most 173 strobes.

// File: rtl/osd_seq_pkg.sv
package osd_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_GLYPH = 2'd1,
      SEQ_SPACE = 2'd2
   } seq_state_t;
endpackage

// File: rtl/height_decode.sv
module height_decode #(
   parameter int INS_BITS = 5,
   parameter int INS_CAP  = 17,
   parameter int HCTL_W   = INS_BITS + 2,
   parameter int CNT_W    = 5
) (
   input  logic [HCTL_W-1:0] ctl,
   output logic [CNT_W-1:0]  ins_cnt,
   output logic [1:0]        whole_rep
);
   localparam int SUM_W = INS_BITS + 1;

   if (HCTL_W != INS_BITS + 2) begin : g_bad_w
      $error("height_decode: HCTL_W must be INS_BITS+2");
   end
   if (INS_CAP >= (1 << CNT_W)) begin : g_bad_cap
      $error("height_decode: INS_CAP does not fit CNT_W");
   end

   logic [SUM_W-1:0] part [INS_BITS+1];
   assign part[0] = '0;

   for (genvar i = 0; i < INS_BITS; i++) begin : g_weight
      assign part[i+1] = part[i] + (ctl[i] ? SUM_W'(1 << i) : SUM_W'(0));
   end

   localparam logic [SUM_W-1:0] CAP_S = SUM_W'(INS_CAP);

   always_comb begin
      if (part[INS_BITS] > CAP_S) ins_cnt = CNT_W'(INS_CAP);
      else                        ins_cnt = CNT_W'(part[INS_BITS]);
   end

   always_comb begin
      if (!ctl[HCTL_W-1])      whole_rep = 2'd0;
      else if (ctl[HCTL_W-2])  whole_rep = 2'd2;
      else                     whole_rep = 2'd1;
   end
endmodule

// File: rtl/repeat_spread.sv
module repeat_spread #(
   parameter int GLYPH_LINES = 18,
   parameter int CNT_W       = 5
) (
   input  logic [CNT_W-1:0] acc_in,
   input  logic [CNT_W-1:0] ins_cnt,
   input  logic [1:0]       whole_rep,
   output logic [CNT_W-1:0] acc_out,
   output logic [1:0]       copies
);
   localparam int SW = CNT_W + 1;
   localparam logic [SW-1:0] LINES_S = SW'(GLYPH_LINES);

   if (GLYPH_LINES > (1 << CNT_W)) begin : g_bad
      $error("repeat_spread: CNT_W too narrow for GLYPH_LINES");
   end

   logic [SW-1:0] sum;
   logic          wrap;

   assign sum     = SW'(acc_in) + SW'(ins_cnt);
   assign wrap    = (sum >= LINES_S);
   assign acc_out = wrap ? CNT_W'(sum - LINES_S) : CNT_W'(sum);
   assign copies  = whole_rep + {1'b0, wrap};
endmodule

// File: rtl/glyph_row_sequencer.sv
module glyph_row_sequencer
   import osd_seq_pkg::*;
#(
   parameter int GLYPH_LINES = 18,
   parameter int INS_BITS    = 5,
   parameter int SPC_W       = 5,
   parameter int HCTL_W      = INS_BITS + 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [HCTL_W-1:0]            height_ctl,
   input  logic                         dbl_height,
   input  logic [SPC_W-1:0]             row_space,
   input  logic                         line_strobe,
   input  logic                         row_start,
   output logic                         line_active,
   output logic [$clog2(GLYPH_LINES)-1:0] glyph_line,
   output logic                         blank_line,
   output logic                         row_end
);
   localparam int IDX_W   = $clog2(GLYPH_LINES);
   localparam int INS_CAP = GLYPH_LINES - 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GLYPH_LINES - 1);

   if (GLYPH_LINES < 2) begin : g_bad_lines
      $error("glyph_row_sequencer: GLYPH_LINES must be at least 2");
   end

   seq_state_t        state;
   logic [IDX_W-1:0]  glyph_q;
   logic [IDX_W-1:0]  acc_q;
   logic [IDX_W-1:0]  ins_q;
   logic [1:0]        whole_q;
   logic [1:0]        copies_q;
   logic              dbl_q;
   logic              dph_q;
   logic [SPC_W-1:0]  space_q;
   logic [SPC_W-1:0]  blank_cnt;

   logic [IDX_W-1:0]  ins_d;
   logic [1:0]        whole_d;
   logic [IDX_W-1:0]  acc_first, acc_nx;
   logic [1:0]        copies_first, copies_nx;

   height_decode #(
      .INS_BITS (INS_BITS),
      .INS_CAP  (INS_CAP),
      .HCTL_W   (HCTL_W),
      .CNT_W    (IDX_W)
   ) u_dec (
      .ctl       (height_ctl),
      .ins_cnt   (ins_d),
      .whole_rep (whole_d)
   );

   repeat_spread #(.GLYPH_LINES(GLYPH_LINES), .CNT_W(IDX_W)) u_first (
      .acc_in    ('0),
      .ins_cnt   (ins_d),
      .whole_rep (whole_d),
      .acc_out   (acc_first),
      .copies    (copies_first)
   );

   repeat_spread #(.GLYPH_LINES(GLYPH_LINES), .CNT_W(IDX_W)) u_next (
      .acc_in    (acc_q),
      .ins_cnt   (ins_q),
      .whole_rep (whole_q),
      .acc_out   (acc_nx),
      .copies    (copies_nx)
   );

   logic half_done;
   assign half_done = !dbl_q || dph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         glyph_q   <= '0;
         acc_q     <= '0;
         ins_q     <= '0;
         whole_q   <= '0;
         copies_q  <= '0;
         dbl_q     <= 1'b0;
         dph_q     <= 1'b0;
         space_q   <= '0;
         blank_cnt <= '0;
      end else if (row_start) begin
         state     <= SEQ_GLYPH;
         glyph_q   <= '0;
         acc_q     <= acc_first;
         ins_q     <= ins_d;
         whole_q   <= whole_d;
         copies_q  <= copies_first;
         dbl_q     <= dbl_height;
         dph_q     <= 1'b0;
         space_q   <= row_space;
         blank_cnt <= '0;
      end else if (line_strobe) begin
         unique case (state)
            SEQ_GLYPH: begin
               if (!half_done) begin
                  dph_q <= 1'b1;
               end else begin
                  dph_q <= 1'b0;
                  if (copies_q != 2'd0) begin
                     copies_q <= copies_q - 2'd1;
                  end else if (glyph_q != LAST_IDX) begin
                     glyph_q  <= glyph_q + IDX_W'(1);
                     acc_q    <= acc_nx;
                     copies_q <= copies_nx;
                  end else if (space_q != '0) begin
                     state     <= SEQ_SPACE;
                     blank_cnt <= space_q - SPC_W'(1);
                  end else begin
                     state <= SEQ_IDLE;
                  end
               end
            end
            SEQ_SPACE: begin
               if (blank_cnt != '0) blank_cnt <= blank_cnt - SPC_W'(1);
               else                 state     <= SEQ_IDLE;
            end
            default: ;
         endcase
      end
   end

   logic glyph_last, space_last;
   assign glyph_last = (state == SEQ_GLYPH) && (glyph_q == LAST_IDX) &&
                       (copies_q == 2'd0) && half_done && (space_q == '0);
   assign space_last = (state == SEQ_SPACE) && (blank_cnt == '0);

   assign line_active = (state != SEQ_IDLE);
   assign blank_line  = (state == SEQ_SPACE);
   assign glyph_line  = (state == SEQ_GLYPH) ? glyph_q : '0;
   assign row_end     = glyph_last || space_last;
endmodule

// File: rtl/glyph_row_sequencer_chk.sv
module glyph_row_sequencer_chk #(
   parameter int IDX_W    = 5,
   parameter int LAST_IDX = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_strobe,
   input logic             row_start,
   input logic             line_active,
   input logic [IDX_W-1:0] glyph_line,
   input logic             blank_line,
   input logic             row_end
);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !line_active |-> (!blank_line && !row_end && glyph_line == '0));

   p_space_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
      blank_line |-> (line_active && glyph_line == '0));

   p_glyph_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      glyph_line <= IDX_W'(LAST_IDX));

   p_start_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      row_start |=> (line_active && !blank_line && glyph_line == '0));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!row_start && !line_strobe) |=> ($stable(glyph_line) && $stable(blank_line)
                                        && $stable(line_active) && $stable(row_end)));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_active && !blank_line && line_strobe && !row_start && !row_end) |=>
      (line_active && (blank_line || glyph_line == $past(glyph_line)
                       || glyph_line == $past(glyph_line) + IDX_W'(1))));

   p_space_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_line && line_strobe && !row_start && !row_end) |=> blank_line);

   p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (row_end && line_strobe && !row_start) |=> !line_active);
endmodule

bind glyph_row_sequencer glyph_row_sequencer_chk #(
   .IDX_W    (IDX_W),
   .LAST_IDX (GLYPH_LINES - 1)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_strobe (line_strobe),
   .row_start   (row_start),
   .line_active (line_active),
   .glyph_line  (glyph_line),
   .blank_line  (blank_line),
   .row_end     (row_end)
);

// File: tb/glyph_row_sequencer_bench.sv
`timescale 1ns/1ps
module glyph_row_sequencer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] height_ctl = '0;
   logic       dbl_height = 1'b0;
   logic [4:0] row_space = '0;
   logic       line_strobe = 1'b0;
   logic       row_start = 1'b0;
   logic       line_active;
   logic [4:0] glyph_line;
   logic       blank_line;
   logic       row_end;

   always #2.5 clk = ~clk;

   glyph_row_sequencer u_glyph_row_sequencer (
      .clk(clk), .rst_n(rst_n), .height_ctl(height_ctl), .dbl_height(dbl_height),
      .row_space(row_space), .line_strobe(line_strobe), .row_start(row_start),
      .line_active(line_active), .glyph_line(glyph_line), .blank_line(blank_line),
      .row_end(row_end)
   );

   int checks = 0;
   int fails  = 0;
   int exp_idx[$];
   int exp_blank[$];

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Reference scan-line list, built from the requirements
   task automatic build(input logic [6:0] h, input bit d, input int s);
      int n, whole, extra;
      exp_idx.delete();
      exp_blank.delete();
      n = int'(h[4:0]);
      if (n > 17) n = 17;
      whole = h[6] ? (h[5] ? 2 : 1) : 0;
      for (int g = 0; g < 18; g++) begin
         extra = ((g + 1) * n) / 18 - (g * n) / 18;
         for (int c = 0; c < 1 + whole + extra; c++) begin
            for (int k = 0; k < (d ? 2 : 1); k++) begin
               exp_idx.push_back(g);
               exp_blank.push_back(0);
            end
         end
      end
      for (int b = 0; b < s; b++) begin
         exp_idx.push_back(0);
         exp_blank.push_back(1);
      end
   endtask

   task automatic check_line(input string req, input int k, input int n);
      chk(req, "line_active", int'(line_active), 1);
      chk(req, "glyph_line", int'(glyph_line), exp_idx[k]);
      chk(req, "blank_line", int'(blank_line), exp_blank[k]);
      chk("R9", "row_end", int'(row_end), (k == n - 1) ? 1 : 0);
   endtask

   task automatic run_row(input string req, input logic [6:0] h, input bit d,
                          input int s, input bit scramble, input int gap);
      int n;
      build(h, d, s);
      n = exp_idx.size();
      @(negedge clk);
      height_ctl = h; dbl_height = d; row_space = 5'(s); row_start = 1'b1;
      @(negedge clk);
      row_start = 1'b0;
      if (scramble) begin
         height_ctl = ~h; dbl_height = ~d; row_space = ~5'(s);
      end
      for (int k = 0; k < n; k++) begin
         check_line(req, k, n);
         if (k % 3 == 0) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               check_line("R2", k, n);
            end
         end
         line_strobe = 1'b1;
         @(negedge clk);
         line_strobe = 1'b0;
      end
      chk("R9", "line_active after row", int'(line_active), 0);
      chk("R9", "row_end after row", int'(row_end), 0);
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "line_active in reset", int'(line_active), 0);
      chk("R1", "glyph_line in reset", int'(glyph_line), 0);
      chk("R1", "blank_line in reset", int'(blank_line), 0);
      chk("R1", "row_end in reset", int'(row_end), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "line_active after reset", int'(line_active), 0);
      chk("R1", "row_end after reset", int'(row_end), 0);

      run_row("R3", 7'h00, 1'b0, 0, 1'b0, 2);   // plain 18 lines
      run_row("R4", 7'h01, 1'b0, 0, 1'b0, 0);   // one inserted line
      run_row("R5", 7'h0B, 1'b0, 0, 1'b0, 1);   // 11 inserted, spread
      run_row("R4", 7'h11, 1'b0, 0, 1'b0, 0);   // exactly 17
      run_row("R4", 7'h12, 1'b0, 0, 1'b0, 0);   // 18 capped to 17
      run_row("R6", 7'h4A, 1'b0, 0, 1'b0, 0);   // 46 lines example
      chk("R6", "example length", exp_idx.size(), 46);
      run_row("R6", 7'h60, 1'b0, 0, 1'b0, 0);   // glyph repeated twice
      run_row("R6", 7'h3F, 1'b0, 0, 1'b0, 0);   // bit 5 alone: no whole repeat
      run_row("R6", 7'h7F, 1'b0, 0, 1'b0, 0);   // 71 lines
      run_row("R7", 7'h05, 1'b1, 0, 1'b0, 1);   // double height
      run_row("R8", 7'h00, 1'b0, 3, 1'b0, 1);   // spacing
      run_row("R8", 7'h42, 1'b1, 31, 1'b0, 0);  // max spacing, not doubled
      run_row("R10", 7'h09, 1'b0, 2, 1'b1, 0);  // inputs change mid-row

      // R11: restart in mid-row
      @(negedge clk);
      height_ctl = 7'h00; dbl_height = 1'b0; row_space = 5'd0; row_start = 1'b1;
      @(negedge clk);
      row_start = 1'b0;
      for (int k = 0; k < 3; k++) begin
         line_strobe = 1'b1;
         @(negedge clk);
         line_strobe = 1'b0;
      end
      chk("R11", "glyph_line before restart", int'(glyph_line), 3);
      run_row("R11", 7'h23, 1'b1, 2, 1'b0, 0);

      // R11: strobes while idle
      for (int k = 0; k < 4; k++) begin
         line_strobe = 1'b1;
         @(negedge clk);
         line_strobe = 1'b0;
         chk("R11", "line_active idle strobe", int'(line_active), 0);
         chk("R11", "glyph_line idle strobe", int'(glyph_line), 0);
      end

      finish_up();
   end
endmodule